// File: doc/BRIEF.md
# Converter Rank Sequencer

This block steps an analog-to-digital converter through a programmed list of up to sixteen rank slots. A start comes either from a software pulse or from one external trigger line, whose active edge is chosen by configuration. For each rank the sequencer puts out the slot's channel number together with the total conversion time for that channel. That time is the channel's own sampling time plus a processing time set by the resolution. It then waits for the converter to report that it has finished.

Three controls shape the run. Scan mode walks through the whole rank list; without it only the first slot is used. Continuous mode restarts the list as soon as it ends. Discontinuous mode cuts the list into short chunks, and each chunk needs a trigger of its own.

Every result is held on a data output. An end-of-conversion flag marks a new result, either after each rank or only after the final rank of the list. A start flag marks each accepted trigger. A sticky overrun flag records that a result arrived while the previous one had not been read. The converter itself sits outside the block, behind a start/done handshake.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `cfg_seq_last` holds the list length minus one (1 to 16 ranks). Rank k, counting from 1, takes its 5-bit channel from `cfg_rank_chan[5(k-1)+4 : 5(k-1)]`. With scan enabled, one pass converts ranks 1 through `cfg_seq_last`+1 in ascending order.
- R2: With `cfg_scan_en` low, each trigger converts only the channel in rank 1, exactly once, whatever `cfg_seq_last` holds.
- R3: With `cfg_cont_en` high, the list starts again at rank 1 straight after its last rank. With it low, the sequencer goes idle after one pass.
- R4: With scan enabled, continuous disabled and `cfg_disc_en` high, each trigger converts at most `cfg_disc_last`+1 ranks (1 to 8). The next trigger resumes at the following rank, and the count wraps to rank 1 after the last rank. In any other mode `cfg_disc_en` has no effect.
- R5: A start request is a high `sw_start` or an edge on `ext_trig` selected by `cfg_trig_edge`: 00 none, 01 rising, 10 falling, 11 both. An edge that is not selected starts nothing.
- R6: `conv_cycles` equals the sampling time of the issued channel plus the processing time. Channel c's 3-bit code sits in `cfg_chan_smp[3c+2 : 3c]`, and codes 0 to 7 give 3, 15, 28, 56, 84, 112, 144 and 480 cycles. `cfg_res` codes 00, 01, 10 and 11 (12, 10, 8 and 6 bits) add 12, 11, 9 and 7 cycles.
- R7: `conv_start` is a one-cycle pulse, with `conv_chan` and `conv_cycles` valid in the same cycle. The next rank is issued only after `conv_done`.
- R8: On the clock edge that samples `conv_done`, `data_out` takes `conv_data`. `eoc_flag` is set on every rank when `cfg_eoc_each` is 1, and only on the final rank of the list when it is 0.
- R9: A `data_rd` pulse clears `eoc_flag`.
- R10: `ovr_flag` is set when a conversion completes while the previous result is still unread. It stays set until `ovr_clr`.
- R11: `strt_flag` is set when a start request is accepted and is cleared by `strt_clr`.
- R12: A start request that arrives while a list or chunk is running is ignored.
- R13: After reset the block is idle with no conversion issued, all flags low and `data_out` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_scan_en | input | 1 | Walk the whole rank list |
| cfg_cont_en | input | 1 | Restart the list automatically |
| cfg_disc_en | input | 1 | Split the list into triggered chunks |
| cfg_disc_last | input | 3 | Chunk length minus one |
| cfg_seq_last | input | 4 | List length minus one |
| cfg_trig_edge | input | 2 | External trigger edge select |
| cfg_eoc_each | input | 1 | 1: flag each rank, 0: flag end of list |
| cfg_res | input | 2 | Resolution code |
| cfg_rank_chan | input | 80 | Channel of each rank slot, 5 bits each |
| cfg_chan_smp | input | 57 | Sampling-time code of each channel, 3 bits each |
| sw_start | input | 1 | Software start pulse |
| ext_trig | input | 1 | External trigger line |
| conv_start | output | 1 | Start pulse to the converter |
| conv_chan | output | 5 | Channel to convert |
| conv_cycles | output | 10 | Total conversion time in cycles |
| conv_done | input | 1 | Converter finished |
| conv_data | input | 12 | Converter result |
| data_out | output | 12 | Last result |
| data_rd | input | 1 | Result read pulse |
| eoc_flag | output | 1 | End-of-conversion flag |
| ovr_flag | output | 1 | Overrun flag |
| ovr_clr | input | 1 | Clears the overrun flag |
| strt_flag | output | 1 | Start-accepted flag |
| strt_clr | input | 1 | Clears the start flag |
| seq_busy | output | 1 | List or chunk in progress |

## Verification
The embedded assertions check the following on every cycle:
- `conv_start` is a single-cycle pulse that always lands inside the effective rank range, and on rank 1 when scan is off.
- A non-continuous pass, and a discontinuous chunk, stop once they reach their last rank.
- The overrun flag sets when it should and then holds.
- A read clears the end-of-conversion flag.
- An accepted start raises the start flag.
- A selected rising edge produces a start request.

Only the bench scenarios can show the rest:
- the exact channel order and the cycle counts for each resolution;
- the resumption and wrap of discontinuous chunks;
- a continuous run stopping cleanly;
- edges that are not selected, and triggers that arrive while busy, producing no extra conversion.

// File: rtl/adc_seq_pkg.sv
// Shared constants, enums and timing functions for the rank sequencer.
// Assumes a fixed 3-bit sampling code and a 10-bit cycle count.
package adc_seq_pkg;
    localparam int SMP_W = 3;
    localparam int CYC_W = 10;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } trig_edge_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } seq_state_e;

    // Sampling time in cycles for a 3-bit code.
    function automatic logic [CYC_W-1:0] sample_cycles(input logic [SMP_W-1:0] code);
        case (code)
            3'd0:    return CYC_W'(3);
            3'd1:    return CYC_W'(15);
            3'd2:    return CYC_W'(28);
            3'd3:    return CYC_W'(56);
            3'd4:    return CYC_W'(84);
            3'd5:    return CYC_W'(112);
            3'd6:    return CYC_W'(144);
            default: return CYC_W'(480);
        endcase
    endfunction

    // Processing time in cycles for a resolution code (12/10/8/6 bits).
    function automatic logic [CYC_W-1:0] proc_cycles(input logic [1:0] res);
        case (res)
            2'd0:    return CYC_W'(12);
            2'd1:    return CYC_W'(11);
            2'd2:    return CYC_W'(9);
            default: return CYC_W'(7);
        endcase
    endfunction
endpackage

// File: rtl/adc_trig_detect.sv
// Turns a software pulse or a selected edge of the external trigger into a
// start request. Assumes ext_trig is already synchronous to clk.
module adc_trig_detect
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_start,
    input  logic       ext_trig,
    input  logic [1:0] edge_sel,
    output logic       start_req
);
    logic ext_q;
    logic rise, fall, hit;

    // Keep last trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_trig;
    end

    assign rise = ext_trig & ~ext_q;
    assign fall = ~ext_trig & ext_q;

    // Select which edge counts as a trigger.
    always_comb begin
        case (trig_edge_e'(edge_sel))
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
    end

    assign start_req = sw_start | hit;

    // R5
    rise_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ext_trig) && edge_sel == 2'b01) |-> start_req);
endmodule

// File: rtl/adc_conv_timing.sv
// Computes the total conversion time of the channel being issued from its
// per-channel sampling code and the resolution. Purely combinational.
module adc_conv_timing
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 19,
    parameter int CHAN_W = 5
) (
    input  logic [NUM_CH*SMP_W-1:0] cfg_chan_smp,
    input  logic [1:0]              cfg_res,
    input  logic [CHAN_W-1:0]       chan,
    output logic [CYC_W-1:0]        cycles
);
    logic [SMP_W-1:0] code_a [NUM_CH];
    logic [SMP_W-1:0] code;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_code
        assign code_a[g] = cfg_chan_smp[g*SMP_W +: SMP_W];
    end

    // Pick the issued channel's code; unknown channels use the shortest time.
    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (chan == CHAN_W'(i)) code = code_a[i];
        end
    end

    assign cycles = sample_cycles(code) + proc_cycles(cfg_res);
endmodule

// File: rtl/adc_rank_seq.sv
// Rank-stepping state machine: accepts starts when idle, issues one rank at a
// time, waits for the converter, and decides between next rank, restart,
// chunk end and list end. Assumes configuration is stable while busy.
module adc_rank_seq
    import adc_seq_pkg::*;
#(
    parameter int MAX_RANKS = 16,
    parameter int MAX_DISC  = 8,
    parameter int CHAN_W    = 5,
    localparam int PTR_W    = $clog2(MAX_RANKS),
    localparam int DISC_W   = $clog2(MAX_DISC)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_scan_en,
    input  logic                        cfg_cont_en,
    input  logic                        cfg_disc_en,
    input  logic [DISC_W-1:0]           cfg_disc_last,
    input  logic [PTR_W-1:0]            cfg_seq_last,
    input  logic [MAX_RANKS*CHAN_W-1:0] cfg_rank_chan,
    input  logic                        start_req,
    input  logic                        conv_done,
    output logic                        conv_start,
    output logic [CHAN_W-1:0]           conv_chan,
    output logic                        seq_busy,
    output logic                        accept,
    output logic                        res_done,
    output logic                        res_last
);
    seq_state_e        state_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [DISC_W-1:0] chunk_q;
    logic [CHAN_W-1:0] rank_a [MAX_RANKS];
    logic              disc_on, at_last, chunk_full;
    logic [PTR_W-1:0]  last_rank;

    for (genvar g = 0; g < MAX_RANKS; g++) begin : g_rank
        assign rank_a[g] = cfg_rank_chan[g*CHAN_W +: CHAN_W];
    end

    assign disc_on    = cfg_scan_en & ~cfg_cont_en & cfg_disc_en;
    assign last_rank  = cfg_scan_en ? cfg_seq_last : '0;
    assign at_last    = (ptr_q >= last_rank);
    assign chunk_full = disc_on & (chunk_q == cfg_disc_last);
    assign accept     = (state_q == ST_IDLE) & start_req;
    assign res_done   = (state_q == ST_WAIT) & conv_done;
    assign res_last   = at_last;
    assign conv_start = (state_q == ST_ISSUE);
    assign seq_busy   = (state_q != ST_IDLE);

    // Channel of the current rank.
    always_comb begin
        conv_chan = '0;
        for (int i = 0; i < MAX_RANKS; i++) begin
            if (ptr_q == PTR_W'(i)) conv_chan = rank_a[i];
        end
    end

    // State, rank pointer and chunk counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            chunk_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_req) begin
                        state_q <= ST_ISSUE;
                        chunk_q <= '0;
                        if (!disc_on) ptr_q <= '0;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                default: begin
                    if (conv_done) begin
                        chunk_q <= chunk_q + 1'b1;
                        if (at_last) begin
                            ptr_q   <= '0;
                            state_q <= cfg_cont_en ? ST_ISSUE : ST_IDLE;
                        end else begin
                            ptr_q   <= ptr_q + 1'b1;
                            state_q <= chunk_full ? ST_IDLE : ST_ISSUE;
                        end
                    end
                end
            endcase
        end
    end

    // R7
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R1
    rank_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (ptr_q <= last_rank));
    // R2
    scan_off_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !cfg_scan_en) |-> (ptr_q == '0));
    // R3
    single_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && at_last && !cfg_cont_en) |=> !seq_busy);
    // R4
    chunk_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && chunk_full && !at_last) |=> !seq_busy);
endmodule

// File: rtl/adc_result_flags.sv
// Holds the last result and the end-of-conversion, overrun and start flags.
// Assumes res_done is a single-cycle pulse per completed rank.
module adc_result_flags #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_done,
    input  logic              res_last,
    input  logic              cfg_eoc_each,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              data_rd,
    input  logic              ovr_clr,
    input  logic              accept,
    input  logic              strt_clr,
    output logic [DATA_W-1:0] data_out,
    output logic              eoc_flag,
    output logic              ovr_flag,
    output logic              strt_flag
);
    logic unread_q;

    // Capture each completed result.
    always_ff @(posedge clk) begin
        if (!rst_n)        data_out <= '0;
        else if (res_done) data_out <= conv_data;
    end

    // End-of-conversion flag at the selected point, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     eoc_flag <= 1'b0;
        else if (res_done && (cfg_eoc_each || res_last)) eoc_flag <= 1'b1;
        else if (data_rd)                               eoc_flag <= 1'b0;
    end

    // Track whether the held result has been read.
    always_ff @(posedge clk) begin
        if (!rst_n)        unread_q <= 1'b0;
        else if (res_done) unread_q <= 1'b1;
        else if (data_rd)  unread_q <= 1'b0;
    end

    // Sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ovr_flag <= 1'b0;
        else if (res_done && unread_q && !data_rd) ovr_flag <= 1'b1;
        else if (ovr_clr)                        ovr_flag <= 1'b0;
    end

    // Start-accepted flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        strt_flag <= 1'b0;
        else if (accept)   strt_flag <= 1'b1;
        else if (strt_clr) strt_flag <= 1'b0;
    end

    // R10
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && unread_q && !data_rd) |=> ovr_flag);
    // R10
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag);
    // R9
    eoc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !res_done) |=> !eoc_flag);
    // R11
    strt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> strt_flag);
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the converter rank sequencer: trigger detection, rank stepping,
// conversion timing and result flags. The analog converter sits outside,
// behind a conv_start / conv_done handshake.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int MAX_RANKS = 16,
    parameter int MAX_DISC  = 8,
    parameter int NUM_CH    = 19,
    parameter int CHAN_W    = 5,
    parameter int DATA_W    = 12,
    localparam int PTR_W    = $clog2(MAX_RANKS),
    localparam int DISC_W   = $clog2(MAX_DISC)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_scan_en,
    input  logic                        cfg_cont_en,
    input  logic                        cfg_disc_en,
    input  logic [DISC_W-1:0]           cfg_disc_last,
    input  logic [PTR_W-1:0]            cfg_seq_last,
    input  logic [1:0]                  cfg_trig_edge,
    input  logic                        cfg_eoc_each,
    input  logic [1:0]                  cfg_res,
    input  logic [MAX_RANKS*CHAN_W-1:0] cfg_rank_chan,
    input  logic [NUM_CH*SMP_W-1:0]     cfg_chan_smp,
    input  logic                        sw_start,
    input  logic                        ext_trig,
    output logic                        conv_start,
    output logic [CHAN_W-1:0]           conv_chan,
    output logic [CYC_W-1:0]            conv_cycles,
    input  logic                        conv_done,
    input  logic [DATA_W-1:0]           conv_data,
    output logic [DATA_W-1:0]           data_out,
    input  logic                        data_rd,
    output logic                        eoc_flag,
    output logic                        ovr_flag,
    input  logic                        ovr_clr,
    output logic                        strt_flag,
    input  logic                        strt_clr,
    output logic                        seq_busy
);
    logic start_req, accept, res_done, res_last;

    adc_trig_detect u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_start  (sw_start),
        .ext_trig  (ext_trig),
        .edge_sel  (cfg_trig_edge),
        .start_req (start_req)
    );

    adc_rank_seq #(
        .MAX_RANKS (MAX_RANKS),
        .MAX_DISC  (MAX_DISC),
        .CHAN_W    (CHAN_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_scan_en   (cfg_scan_en),
        .cfg_cont_en   (cfg_cont_en),
        .cfg_disc_en   (cfg_disc_en),
        .cfg_disc_last (cfg_disc_last),
        .cfg_seq_last  (cfg_seq_last),
        .cfg_rank_chan (cfg_rank_chan),
        .start_req     (start_req),
        .conv_done     (conv_done),
        .conv_start    (conv_start),
        .conv_chan     (conv_chan),
        .seq_busy      (seq_busy),
        .accept        (accept),
        .res_done      (res_done),
        .res_last      (res_last)
    );

    adc_conv_timing #(
        .NUM_CH (NUM_CH),
        .CHAN_W (CHAN_W)
    ) u_timing (
        .cfg_chan_smp (cfg_chan_smp),
        .cfg_res      (cfg_res),
        .chan         (conv_chan),
        .cycles       (conv_cycles)
    );

    adc_result_flags #(
        .DATA_W (DATA_W)
    ) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .res_done     (res_done),
        .res_last     (res_last),
        .cfg_eoc_each (cfg_eoc_each),
        .conv_data    (conv_data),
        .data_rd      (data_rd),
        .ovr_clr      (ovr_clr),
        .accept       (accept),
        .strt_clr     (strt_clr),
        .data_out     (data_out),
        .eoc_flag     (eoc_flag),
        .ovr_flag     (ovr_flag),
        .strt_flag    (strt_flag)
    );
endmodule

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_scan_en = 1'b0, cfg_cont_en = 1'b0, cfg_disc_en = 1'b0;
    logic [2:0] cfg_disc_last = '0;
    logic [3:0] cfg_seq_last = '0;
    logic [1:0] cfg_trig_edge = '0;
    logic cfg_eoc_each = 1'b1;
    logic [1:0] cfg_res = '0;
    logic [79:0] cfg_rank_chan = '0;
    logic [56:0] cfg_chan_smp = '0;
    logic sw_start = 1'b0, ext_trig = 1'b0;
    logic conv_start;
    logic [4:0] conv_chan;
    logic [9:0] conv_cycles;
    logic conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic [11:0] data_out;
    logic data_rd;
    logic eoc_flag, ovr_flag, strt_flag, seq_busy;
    logic ovr_clr = 1'b0, strt_clr = 1'b0;
    logic rd_pulse = 1'b0, man_rd = 1'b0;

    int n_chk = 0, n_fail = 0;
    int rank_ch [16];
    logic [15:0] exp_q [$];
    bit auto_rd = 1'b1;
    bit chk_pend = 1'b0;
    bit cur_eoc = 1'b0;
    int cv_cnt = 0;
    logic [4:0] cv_ch = '0;
    logic [6:0] cv_seq = '0;
    logic [11:0] last_data = '0;
    logic [15:0] it;
    bit done_flag = 1'b0;

    assign data_rd = rd_pulse | man_rd;

    always #10 clk = ~clk;

    adc_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_scan_en(cfg_scan_en), .cfg_cont_en(cfg_cont_en), .cfg_disc_en(cfg_disc_en),
        .cfg_disc_last(cfg_disc_last), .cfg_seq_last(cfg_seq_last),
        .cfg_trig_edge(cfg_trig_edge), .cfg_eoc_each(cfg_eoc_each), .cfg_res(cfg_res),
        .cfg_rank_chan(cfg_rank_chan), .cfg_chan_smp(cfg_chan_smp),
        .sw_start(sw_start), .ext_trig(ext_trig),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_cycles(conv_cycles),
        .conv_done(conv_done), .conv_data(conv_data),
        .data_out(data_out), .data_rd(data_rd),
        .eoc_flag(eoc_flag), .ovr_flag(ovr_flag), .ovr_clr(ovr_clr),
        .strt_flag(strt_flag), .strt_clr(strt_clr), .seq_busy(seq_busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int smp_cyc(input int code);
        case (code)
            0: return 3;   1: return 15;  2: return 28;  3: return 56;
            4: return 84;  5: return 112; 6: return 144; default: return 480;
        endcase
    endfunction

    function automatic int proc_cyc(input int res);
        case (res)
            0: return 12; 1: return 11; 2: return 9; default: return 7;
        endcase
    endfunction

    // Driver: expected conversion for rank index k (0-based).
    task automatic push_rank(input int k, input bit eoc_e);
        int ch;
        int cyc;
        ch  = rank_ch[k];
        cyc = smp_cyc(ch % 8) + proc_cyc(int'(cfg_res));
        exp_q.push_back({eoc_e, 10'(cyc), 5'(ch)});
    endtask

    task automatic pulse_sw();
        @(negedge clk) sw_start = 1'b1;
        @(negedge clk) sw_start = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (4) @(negedge clk);
        while (seq_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic read_once();
        @(negedge clk) man_rd = 1'b1;
        @(negedge clk) man_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    // Converter model and scoreboard monitor.
    always @(negedge clk) begin
        rd_pulse  = 1'b0;
        conv_done = 1'b0;
        if (chk_pend) begin
            chk_pend = 1'b0;
            chk(data_out == last_data, "R8 data_out", int'(data_out), int'(last_data));
            chk(eoc_flag == cur_eoc, "R8 eoc_flag", int'(eoc_flag), int'(cur_eoc));
            if (auto_rd) rd_pulse = 1'b1;
        end
        if (conv_start) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12 unexpected conversion", int'(conv_chan), -1);
            end else begin
                it = exp_q.pop_front();
                chk(conv_chan == it[4:0], "R1 channel", int'(conv_chan), int'(it[4:0]));
                chk(conv_cycles == it[14:5], "R6 cycles", int'(conv_cycles), int'(it[14:5]));
                cur_eoc = it[15];
            end
            cv_cnt = int'(conv_cycles);
            cv_ch  = conv_chan;
        end else if (cv_cnt > 0) begin
            cv_cnt--;
            if (cv_cnt == 0) begin
                conv_done = 1'b1;
                cv_seq    = cv_seq + 1'b1;
                conv_data = {cv_ch, cv_seq};
                last_data = conv_data;
                chk_pend  = 1'b1;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R7 watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int k = 0; k < 16; k++) begin
            rank_ch[k] = (k * 7 + 3) % 19;
            cfg_rank_chan[k*5 +: 5] = 5'(rank_ch[k]);
        end
        for (int c = 0; c < 19; c++) cfg_chan_smp[c*3 +: 3] = 3'(c % 8);

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(!conv_start, "R13 conv_start", int'(conv_start), 0);
        chk(!seq_busy, "R13 seq_busy", int'(seq_busy), 0);
        chk(!eoc_flag && !ovr_flag && !strt_flag, "R13 flags",
            int'({eoc_flag, ovr_flag, strt_flag}), 0);
        chk(data_out == 12'h0, "R13 data_out", int'(data_out), 0);

        // R1 four-rank scan, flag per rank; R11 start flag
        cfg_scan_en = 1'b1; cfg_seq_last = 4'd3; cfg_eoc_each = 1'b1; auto_rd = 1'b1;
        for (int k = 0; k < 4; k++) push_rank(k, 1'b1);
        pulse_sw();
        chk(strt_flag, "R11 strt_flag set", int'(strt_flag), 1);
        wait_idle();
        chk(exp_q.size() == 0, "R1 all ranks issued", exp_q.size(), 0);
        chk(!ovr_flag, "R10 no overrun when read", int'(ovr_flag), 0);
        @(negedge clk) strt_clr = 1'b1;
        @(negedge clk) strt_clr = 1'b0;
        chk(!strt_flag, "R11 strt_flag cleared", int'(strt_flag), 0);

        // R6 every resolution
        for (int r = 0; r < 4; r++) begin
            cfg_res = 2'(r);
            cfg_seq_last = 4'(r + 1);
            for (int k = 0; k <= r + 1; k++) push_rank(k, 1'b1);
            pulse_sw();
            wait_idle();
            chk(exp_q.size() == 0, "R6 resolution pass", exp_q.size(), 0);
        end
        cfg_res = 2'd0;

        // R2 scan off: rank 1 only; R4 split ignored here
        cfg_scan_en = 1'b0; cfg_seq_last = 4'd5; cfg_disc_en = 1'b1; cfg_disc_last = 3'd0;
        push_rank(0, 1'b1);
        pulse_sw();
        wait_idle();
        chk(exp_q.size() == 0 && !seq_busy, "R2 single rank", exp_q.size(), 0);
        cfg_disc_en = 1'b0;

        // R8 end-of-list flag, R10 overrun, R9 read clears
        cfg_scan_en = 1'b1; cfg_seq_last = 4'd2; cfg_eoc_each = 1'b0; auto_rd = 1'b0;
        push_rank(0, 1'b0); push_rank(1, 1'b0); push_rank(2, 1'b1);
        pulse_sw();
        wait_idle();
        chk(ovr_flag, "R10 overrun set", int'(ovr_flag), 1);
        read_once();
        chk(!eoc_flag, "R9 eoc cleared by read", int'(eoc_flag), 0);
        repeat (5) @(negedge clk);
        chk(ovr_flag, "R10 overrun sticky", int'(ovr_flag), 1);
        @(negedge clk) ovr_clr = 1'b1;
        @(negedge clk) ovr_clr = 1'b0;
        chk(!ovr_flag, "R10 overrun cleared", int'(ovr_flag), 0);
        auto_rd = 1'b1;

        // R4 discontinuous chunks of two over five ranks, then wrap
        cfg_eoc_each = 1'b1; cfg_seq_last = 4'd4; cfg_disc_en = 1'b1; cfg_disc_last = 3'd1;
        push_rank(0, 1'b1); push_rank(1, 1'b1);
        pulse_sw(); wait_idle();
        chk(exp_q.size() == 0, "R4 chunk 1", exp_q.size(), 0);
        push_rank(2, 1'b1); push_rank(3, 1'b1);
        pulse_sw(); wait_idle();
        chk(exp_q.size() == 0, "R4 chunk 2", exp_q.size(), 0);
        push_rank(4, 1'b1);
        pulse_sw(); wait_idle();
        chk(exp_q.size() == 0, "R4 short last chunk", exp_q.size(), 0);
        push_rank(0, 1'b1); push_rank(1, 1'b1);
        pulse_sw(); wait_idle();
        chk(exp_q.size() == 0, "R4 wrap to rank 1", exp_q.size(), 0);

        // R3 continuous restart (split setting ignored), stop after three passes
        cfg_cont_en = 1'b1; cfg_seq_last = 4'd1; cfg_eoc_each = 1'b0;
        for (int p = 0; p < 3; p++) begin
            push_rank(0, 1'b0); push_rank(1, 1'b1);
        end
        pulse_sw();
        while (exp_q.size() != 0) @(negedge clk);
        cfg_cont_en = 1'b0;
        wait_idle();
        chk(!seq_busy, "R3 stops after pass", int'(seq_busy), 0);
        cfg_disc_en = 1'b0; cfg_eoc_each = 1'b1;

        // R5 external trigger edges, scan off so one conversion per start
        cfg_scan_en = 1'b0;
        cfg_trig_edge = 2'b00;
        @(negedge clk) ext_trig = 1'b1;
        repeat (3) @(negedge clk); ext_trig = 1'b0;
        repeat (5) @(negedge clk);
        chk(!seq_busy, "R5 edge none no start", int'(seq_busy), 0);
        cfg_trig_edge = 2'b01;
        push_rank(0, 1'b1);
        @(negedge clk) ext_trig = 1'b1;
        wait_idle();
        chk(exp_q.size() == 0, "R5 rising start", exp_q.size(), 0);
        ext_trig = 1'b0;
        repeat (5) @(negedge clk);
        chk(!seq_busy, "R5 falling ignored in rising mode", int'(seq_busy), 0);
        cfg_trig_edge = 2'b10;
        ext_trig = 1'b1;
        repeat (5) @(negedge clk);
        chk(!seq_busy, "R5 rising ignored in falling mode", int'(seq_busy), 0);
        push_rank(0, 1'b1);
        ext_trig = 1'b0;
        wait_idle();
        chk(exp_q.size() == 0, "R5 falling start", exp_q.size(), 0);
        cfg_trig_edge = 2'b11;
        push_rank(0, 1'b1);
        ext_trig = 1'b1;
        wait_idle();
        push_rank(0, 1'b1);
        ext_trig = 1'b0;
        wait_idle();
        chk(exp_q.size() == 0, "R5 both edges start", exp_q.size(), 0);

        // R12 starts during a running list are ignored
        cfg_scan_en = 1'b1; cfg_seq_last = 4'd1;
        push_rank(0, 1'b1); push_rank(1, 1'b1);
        pulse_sw();
        repeat (5) @(negedge clk);
        pulse_sw();
        ext_trig = 1'b1;
        repeat (3) @(negedge clk);
        ext_trig = 1'b0;
        wait_idle();
        chk(exp_q.size() == 0 && !seq_busy, "R12 busy triggers ignored", exp_q.size(), 0);

        finish_run();
    end
endmodule